// File: doc/BRIEF.md
# Multi-Mode 16-bit Down-Counting Timer

This block is a down-counter with a reload latch. It runs in one of four modes. In interval mode it counts an externally prescaled enable. In pulse mode it toggles a pin on every underflow. In event mode it counts edges on an external pin. In width mode it counts the prescaled enable only while the pin sits at a chosen level. An underflow happens when the counter is at zero and a count enable arrives. On underflow the counter reloads from the latch and raises a one-clock timer interrupt request. A separate request flags the selected edge on the external pin.

Software writes the 16-bit value as two bytes, low then high. Nothing changes in the counter or latch until the high byte arrives, so the counter never holds a half-written word. A write-control input picks one of two behaviours:
- a direct load, where the counter and latch are written together;
- a latch-only load, where the new value waits for the next underflow. A high-byte write that lands exactly on an underflow moves the written value straight into the counter.

Top module: `multi_mode_timer`

## Requirements
- R1: After reset the count reads 0, and `irq_tmr`, `irq_pin`, `pin_out` and `pin_oe` are all 0.
- R2: In interval mode (`mode`=0) the count drops by one at each clock where `presc_tick` is 1. `src_sel` has no effect.
- R3: When the count is 0 and a count enable occurs, the counter reloads from the latch and `irq_tmr` is 1 for that single following cycle.
- R4: `pin_oe` is 1 exactly when `mode`=1 (pulse mode). In that mode `pin_out` inverts on each underflow, and the inverted level is visible together with the reload.
- R5: In pulse mode with `src_sel`=1 the counter counts on every clock, whatever `presc_tick` is. With `src_sel`=0 it counts `presc_tick`.
- R6: In event mode (`mode`=2) the count drops once per edge of `pin_in`: the rising edge when `edge_sel`=0, the falling edge when `edge_sel`=1. `pin_in` passes through two synchronizer flops, so a change is counted on the third clock edge after it. `presc_tick` is ignored.
- R7: In width mode (`mode`=3) the counter counts `presc_tick` only while the synchronized `pin_in` is 1 (`edge_sel`=0) or 0 (`edge_sel`=1).
- R8: A write with `wr_hi`=0 only stores the low byte and leaves the count unchanged. A write with `wr_hi`=1 commits the word {`wr_data`, stored low byte}.
- R9: With `wr_ctl`=0 a high-byte write loads both the counter and the latch. This load wins over any count in the same cycle.
- R10: With `wr_ctl`=1 a high-byte write loads only the latch. The counter keeps its value or keeps counting, and the next underflow loads the new latch value.
- R11: With `wr_ctl`=1, a high-byte write in the same cycle as an underflow puts the written word into the counter.
- R12: `irq_pin` is 1 for one cycle on the synchronized rising edge of `pin_in` when `edge_sel`=0, or on the falling edge when `edge_sel`=1. It is visible on the third clock edge after the pin change, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | 0 selects the low byte, 1 selects the high byte (commit) |
| wr_data | input | 8 | Byte being written |
| wr_ctl | input | 1 | 0 for a direct load, 1 for a latch-only load |
| mode | input | 2 | 0 interval, 1 pulse, 2 event, 3 width |
| src_sel | input | 1 | In pulse mode, 1 counts every clock |
| edge_sel | input | 1 | Active edge and level select |
| presc_tick | input | 1 | Prescaled count enable from outside |
| pin_in | input | 1 | External pin sample |
| pin_out | output | 1 | Pulse-mode pin level |
| pin_oe | output | 1 | Pin drive enable |
| count | output | 16 | Current counter value |
| irq_tmr | output | 1 | Underflow interrupt request |
| irq_pin | output | 1 | Pin edge interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter and two synchronizer stages. Written high bytes are kept to 0 or 1, and low bytes are kept small. This makes underflows, reload chains and writes that coincide with an underflow frequent within a few thousand cycles. It also puts zero-latch reloads within reach: with every-clock counting in pulse mode, these give back-to-back interrupt requests.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_PULSE    = 2'd1,
    MODE_EVENT    = 2'd2,
    MODE_WIDTH    = 2'd3
  } mmt_mode_e;

  // Edge chosen by the active-edge bit: 0 rising, 1 falling.
  function automatic logic pick_edge(input logic sel, input logic rise, input logic fall);
    return sel ? fall : rise;
  endfunction

  // Level gate for width mode: high counts when sel=0, low counts when sel=1.
  function automatic logic level_active(input logic sel, input logic lvl);
    return lvl ^ sel;
  endfunction

endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign level = chain_q[LAST-1];
  assign rise  = chain_q[LAST-1] & ~chain_q[LAST];
  assign fall  = ~chain_q[LAST-1] & chain_q[LAST];

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));  // R6

  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> level);  // R12

endmodule

// File: rtl/mmt_tick_sel.sv
module mmt_tick_sel
  import mmt_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       src_sel,
  input  logic       edge_sel,
  input  logic       presc_tick,
  input  logic       level,
  input  logic       rise,
  input  logic       fall,
  output logic       tick
);
  mmt_mode_e mode_e;
  assign mode_e = mmt_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      MODE_INTERVAL: tick = presc_tick;
      MODE_PULSE:    tick = src_sel ? 1'b1 : presc_tick;
      MODE_EVENT:    tick = pick_edge(edge_sel, rise, fall);
      MODE_WIDTH:    tick = presc_tick & level_active(edge_sel, level);
      default:       tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/mmt_core.sv
module mmt_core #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 lo_wr,
  input  logic                 hi_wr,
  input  logic [CNT_W/2-1:0]   wr_byte,
  input  logic                 wr_ctl,
  output logic [CNT_W-1:0]     count,
  output logic                 underflow,
  output logic                 irq_tmr
);
  localparam int BYTE_W = CNT_W / 2;

  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  latch_q, cnt_q, cnt_d, wr_word;
  logic              irq_q;

  assign wr_word   = {wr_byte, lo_q};
  assign underflow = tick && (cnt_q == '0);

  function automatic logic [CNT_W-1:0] cnt_next(
    input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] rld,
    input logic [CNT_W-1:0] word, input logic commit, input logic latch_only,
    input logic step, input logic uf);
    if (commit && !latch_only) return word;
    if (uf)                    return commit ? word : rld;
    if (step)                  return cur - 1'b1;
    return cur;
  endfunction

  always_comb cnt_d = cnt_next(cnt_q, latch_q, wr_word, hi_wr, wr_ctl, tick, underflow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      latch_q <= '0;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (lo_wr) lo_q <= wr_byte;
      if (hi_wr) latch_q <= wr_word;
      cnt_q <= cnt_d;
      irq_q <= underflow;
    end
  end

  assign count   = cnt_q;
  assign irq_tmr = irq_q;

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !hi_wr) |=> cnt_q == $past(cnt_q) - 1'b1);  // R2

  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !hi_wr) |=> (cnt_q == latch_q) && irq_tmr);  // R3

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !wr_ctl) |=> cnt_q == latch_q);  // R9

  AST_LATCH_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && wr_ctl && !tick) |=> $stable(cnt_q));  // R10

  AST_COINCIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && wr_ctl && underflow) |=> cnt_q == latch_q);  // R11

  AST_LOW_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !tick) |=> $stable(cnt_q));  // R8

endmodule

// File: rtl/multi_mode_timer.sv
module multi_mode_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic             wr_ctl,
  input  logic [1:0]       mode,
  input  logic             src_sel,
  input  logic             edge_sel,
  input  logic             presc_tick,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [CNT_W-1:0] count,
  output logic             irq_tmr,
  output logic             irq_pin
);
  logic pin_level, pin_rise, pin_fall;
  logic tick, underflow;
  logic pulse_q, edge_irq_q;
  logic is_pulse;

  assign is_pulse = (mmt_mode_e'(mode) == MODE_PULSE);

  mmt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in),
    .level(pin_level), .rise(pin_rise), .fall(pin_fall)
  );

  mmt_tick_sel u_tick (
    .mode(mode), .src_sel(src_sel), .edge_sel(edge_sel), .presc_tick(presc_tick),
    .level(pin_level), .rise(pin_rise), .fall(pin_fall), .tick(tick)
  );

  mmt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .lo_wr(wr_en && !wr_hi), .hi_wr(wr_en && wr_hi),
    .wr_byte(wr_data), .wr_ctl(wr_ctl),
    .count(count), .underflow(underflow), .irq_tmr(irq_tmr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q    <= 1'b0;
      edge_irq_q <= 1'b0;
    end else begin
      if (is_pulse && underflow) pulse_q <= ~pulse_q;
      edge_irq_q <= pick_edge(edge_sel, pin_rise, pin_fall);
    end
  end

  assign pin_out = pulse_q;
  assign pin_oe  = is_pulse;
  assign irq_pin = edge_irq_q;

  AST_PULSE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pulse && underflow) |=> pin_out != $past(pin_out));  // R4

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !underflow |=> $stable(pin_out));  // R4

  AST_WIDTH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mmt_mode_e'(mode) == MODE_WIDTH && tick) |-> (pin_level != edge_sel) && presc_tick);  // R7

  AST_EVENT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mmt_mode_e'(mode) == MODE_EVENT && tick) |-> (pin_rise || pin_fall));  // R6

endmodule

// File: tb/tb_multi_mode_timer.sv
module tb_multi_mode_timer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, wr_hi, wr_ctl, src_sel, edge_sel, presc_tick, pin_in;
  logic [7:0]  wr_data;
  logic [1:0]  mode;
  logic        pin_out, pin_oe, irq_tmr, irq_pin;
  logic [15:0] count;

  multi_mode_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .mode(mode), .src_sel(src_sel), .edge_sel(edge_sel),
    .presc_tick(presc_tick), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .count(count), .irq_tmr(irq_tmr), .irq_pin(irq_pin)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Behavioural reference state
  logic        m_p1, m_p2, m_p3;
  logic [7:0]  m_lo;
  logic [15:0] m_latch, m_cnt;
  logic        m_irq, m_eirq, m_pout;

  function automatic logic ref_en(input logic [1:0] md, input logic ss, input logic es,
                                  input logic pt, input logic lv, input logic prv);
    case (md)
      2'd0: return pt;
      2'd1: return ss | pt;
      2'd2: return es ? (!lv && prv) : (lv && !prv);
      default: return pt && (es ? !lv : lv);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p1 <= 0; m_p2 <= 0; m_p3 <= 0; m_lo <= 0; m_latch <= 0; m_cnt <= 0;
      m_irq <= 0; m_eirq <= 0; m_pout <= 0;
    end else begin
      logic en, uf, commit;
      logic [15:0] word;
      en = ref_en(mode, src_sel, edge_sel, presc_tick, m_p2, m_p3);
      uf = en && (m_cnt == 16'd0);
      commit = wr_en && wr_hi;
      word = {wr_data, m_lo};
      m_p1 <= pin_in; m_p2 <= m_p1; m_p3 <= m_p2;
      if (wr_en && !wr_hi) m_lo <= wr_data;
      if (commit) m_latch <= word;
      if (commit && !wr_ctl)   m_cnt <= word;
      else if (uf)             m_cnt <= commit ? word : m_latch;
      else if (en)             m_cnt <= m_cnt - 16'd1;
      m_irq  <= uf;
      m_eirq <= edge_sel ? (!m_p2 && m_p3) : (m_p2 && !m_p3);
      if (uf && mode == 2'd1) m_pout <= ~m_pout;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(cur_req, "count",   count,   m_cnt);
    chk(cur_req, "irq_tmr", irq_tmr, m_irq);
    chk(cur_req, "irq_pin", irq_pin, m_eirq);
    chk(cur_req, "pin_out", pin_out, m_pout);
    chk("R4",    "pin_oe",  pin_oe,  mode == 2'd1);
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic put_byte(input logic hi, input logic [7:0] b, input logic ctl);
    wr_en = 1; wr_hi = hi; wr_data = b; wr_ctl = ctl;
    cyc();
    wr_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d));
    rst_n = 0; wr_en = 0; wr_hi = 0; wr_data = 0; wr_ctl = 0; mode = 0;
    src_sel = 0; edge_sel = 0; presc_tick = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", count, 0);
    chk("R1", "irq_tmr", irq_tmr, 0);
    chk("R1", "irq_pin", irq_pin, 0);
    chk("R1", "pin_out", pin_out, 0);
    chk("R1", "pin_oe", pin_oe, 0);

    // R8 low byte alone changes nothing, high byte commits
    cur_req = "R8";
    put_byte(0, 8'h34, 0);
    chk("R8", "count after low byte", count, 16'h0000);
    cur_req = "R9";
    put_byte(1, 8'h12, 0);
    chk("R9", "count after direct load", count, 16'h1234);

    // R2 interval counting, src_sel ignored
    cur_req = "R2";
    src_sel = 1; presc_tick = 1;
    repeat (3) cyc();
    presc_tick = 0;
    chk("R2", "count after 3 ticks", count, 16'h1231);
    cyc();
    chk("R2", "count held without tick", count, 16'h1231);

    // R10 latch-only write leaves counter untouched
    cur_req = "R10";
    put_byte(0, 8'h02, 1);
    put_byte(1, 8'h00, 1);
    chk("R10", "count after latch-only", count, 16'h1231);

    // R11 latch-only write coinciding with underflow
    cur_req = "R11";
    put_byte(0, 8'h00, 0);
    put_byte(1, 8'h00, 0);
    chk("R11", "count zeroed", count, 16'h0000);
    put_byte(0, 8'h05, 1);
    presc_tick = 1;
    put_byte(1, 8'h00, 1);
    chk("R11", "count takes written word", count, 16'h0005);
    chk("R3", "irq_tmr on underflow", irq_tmr, 1);

    // R3 count down and reload from latch
    cur_req = "R3";
    repeat (5) cyc();
    chk("R3", "count at zero", count, 16'h0000);
    cyc();
    chk("R3", "reload from latch", count, 16'h0005);
    chk("R3", "irq_tmr pulse", irq_tmr, 1);
    presc_tick = 0;
    cyc();
    chk("R3", "irq_tmr single cycle", irq_tmr, 0);

    // Mode phases with random stimulus, checked each cycle against the model
    for (int ph = 0; ph < 8; ph++) begin
      mode = ph[1:0];
      edge_sel = ph[2];
      case (ph % 4)
        0: cur_req = "R2";
        1: cur_req = "R5";
        2: cur_req = "R6";
        default: cur_req = "R7";
      endcase
      for (int i = 0; i < 700; i++) begin
        presc_tick = ($urandom % 3) == 0;
        src_sel = (ph == 1) ? (i < 350) : $urandom % 2;
        if (($urandom % 3) == 0) pin_in = ~pin_in;
        wr_en = ($urandom % 9) == 0;
        wr_hi = $urandom % 2;
        wr_ctl = $urandom % 2;
        wr_data = wr_hi ? 8'($urandom % 2) : 8'($urandom % 12);
        cyc();
      end
      wr_en = 0;
    end

    // R12 directed edge interrupt latency
    cur_req = "R12";
    mode = 0; edge_sel = 0; presc_tick = 0; pin_in = 0;
    repeat (4) cyc();
    pin_in = 1;
    cyc(); cyc();
    chk("R12", "irq_pin not yet", irq_pin, 0);
    cyc();
    chk("R12", "irq_pin on rising", irq_pin, 1);
    cyc();
    chk("R12", "irq_pin one cycle", irq_pin, 0);

    // R4 zero latch with every-clock counting toggles pin each cycle
    cur_req = "R4";
    mode = 1; src_sel = 1;
    put_byte(0, 8'h00, 0);
    put_byte(1, 8'h00, 0);
    repeat (6) cyc();
    chk("R4", "pin_oe in pulse mode", pin_oe, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule